// File: doc/BRIEF.md
# Two-Thread Register Alias Table

This block renames architectural registers for a core that runs two hardware threads at once. Both threads share one pool of physical registers. Each thread keeps a separate speculative map, so register 5 in one thread and register 5 in the other never resolve to the same physical register. Each rename request carries a thread number, two source register numbers and an optional destination. The block returns the current physical tags of the sources. When a destination is present, it also hands out a fresh physical register from the free pool and records it as that register's newest mapping.

Each thread also has an architected map, which holds the mappings of retired instructions. A retirement (commit) writes the retiring tag into that map. The physical register it replaces goes back to the pool. A flush of one thread rebuilds that thread's speculative map from its architected map and returns every register the thread had allocated but not yet retired. The other thread's state does not change.

Top module: `thread_rename_table`

## Requirements
- R1: After reset, thread t maps architectural register r to physical register t*16+r. Physical registers 32 to 63 are free.
- R2: Source tags come from the requesting thread's own speculative map. The same register number in thread 0 and thread 1 gives different tags unless a commit or flush made them equal.
- R3: A rename with a destination receives the lowest-numbered free physical register. That register was mapped nowhere before. It becomes the thread's new mapping for the destination.
- R4: Sources are looked up before the destination is written. A source equal to the instruction's own destination gets the previous mapping. Any later rename in the same thread that reads that register gets the new tag.
- R5: `rn_ready` is low for a rename with a destination while no physical register is free. A rename without a destination is still accepted.
- R6: A commit of (thread, register, tag) writes the tag into that thread's architected map and frees the tag it replaces. The freed tag can be allocated from the next cycle on.
- R7: A flush copies the thread's architected map into its speculative map and frees all of that thread's unretired allocations. A commit of the same thread in the same cycle is included in the copy.
- R8: A flush of one thread leaves the other thread's speculative mappings and allocations unchanged.
- R9: While `fl_valid` is high, a rename of the flushed thread is not accepted (`rn_ready` low). A rename of the other thread is unaffected.
- R10: A rename is accepted on a rising edge with `rn_valid` and `rn_ready` high. On that edge `out_valid` rises with the echoed thread and tags. It is low after every edge without an accepted rename, including during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rn_valid | input | 1 | Rename request present |
| rn_tid | input | 1 | Thread of the rename |
| rn_src0 | input | 4 | First source register |
| rn_src1 | input | 4 | Second source register |
| rn_dst_en | input | 1 | Rename has a destination |
| rn_dst | input | 4 | Destination register |
| rn_ready | output | 1 | Rename can be accepted this cycle |
| cm_valid | input | 1 | Commit present |
| cm_tid | input | 1 | Thread of the commit |
| cm_areg | input | 4 | Retiring destination register |
| cm_ptag | input | 6 | Physical tag being retired |
| fl_valid | input | 1 | Flush request |
| fl_tid | input | 1 | Thread to flush |
| out_valid | output | 1 | Rename result valid |
| out_tid | output | 1 | Thread of the result |
| out_dst_en | output | 1 | Result carries a new destination tag |
| out_ps0 | output | 6 | Physical tag of source 0 |
| out_ps1 | output | 6 | Physical tag of source 1 |
| out_pd | output | 6 | New destination tag (meaningful when out_dst_en) |

## Verification
A corrupted speculative map shows up as a wrong source tag on the next rename that reads the damaged entry. It appears on the edge that accepts that rename, so the bench reads every source tag through renames and compares them with a model of both threads. A pool that wrongly marks a register free or busy shows up immediately in a different `out_pd`, because allocation is deterministic, lowest free index first. It also shows up in `rn_ready` stalling too early or too late when the pool runs dry. Flush and commit faults appear at the first rename that reads a restored register or receives a recycled tag.

// File: rtl/thread_rename_pkg.sv
package thread_rename_pkg;
  typedef enum logic [1:0] {
    PR_FREE = 2'd0,
    PR_SPEC = 2'd1,
    PR_ARCH = 2'd2
  } preg_state_e;
endpackage

// File: rtl/thread_rename_spec_map.sv
module thread_rename_spec_map #(
  parameter int NT = 2,
  parameter int NA = 16,
  parameter int NP = 64,
  localparam int TW = $clog2(NT),
  localparam int AW = $clog2(NA),
  localparam int PW = $clog2(NP)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [TW-1:0]          rd_tid,
  input  logic [AW-1:0]          rd_a0,
  input  logic [AW-1:0]          rd_a1,
  output logic [PW-1:0]          rd_p0,
  output logic [PW-1:0]          rd_p1,
  input  logic                   wr_en,
  input  logic [TW-1:0]          wr_tid,
  input  logic [AW-1:0]          wr_a,
  input  logic [PW-1:0]          wr_p,
  input  logic                   ld_en,
  input  logic [TW-1:0]          ld_tid,
  input  logic [NA-1:0][PW-1:0]  ld_row
);
  logic [PW-1:0] map_q [NT][NA];

  assign rd_p0 = map_q[rd_tid][rd_a0];
  assign rd_p1 = map_q[rd_tid][rd_a1];

  // A flush reloads one thread's row; the rename write targets the other thread
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int t = 0; t < NT; t++)
        for (int r = 0; r < NA; r++)
          map_q[t][r] <= PW'(t * NA + r);
    end else begin
      for (int t = 0; t < NT; t++)
        if (ld_en && ld_tid == TW'(t))
          for (int r = 0; r < NA; r++)
            map_q[t][r] <= ld_row[r];
      if (wr_en)
        map_q[wr_tid][wr_a] <= wr_p;
    end
  end
endmodule

// File: rtl/thread_rename_arch_map.sv
module thread_rename_arch_map #(
  parameter int NT = 2,
  parameter int NA = 16,
  parameter int NP = 64,
  localparam int TW = $clog2(NT),
  localparam int AW = $clog2(NA),
  localparam int PW = $clog2(NP)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cm_en,
  input  logic [TW-1:0]          cm_tid,
  input  logic [AW-1:0]          cm_a,
  input  logic [PW-1:0]          cm_p,
  output logic [PW-1:0]          old_p,
  input  logic [TW-1:0]          row_tid,
  output logic [NA-1:0][PW-1:0]  row_nxt
);
  logic [PW-1:0] map_q [NT][NA];

  assign old_p = map_q[cm_tid][cm_a];

  // Next-state view of one thread's row, including a commit in this cycle
  always_comb begin
    for (int r = 0; r < NA; r++)
      row_nxt[r] = map_q[row_tid][r];
    if (cm_en && cm_tid == row_tid)
      row_nxt[cm_a] = cm_p;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int t = 0; t < NT; t++)
        for (int r = 0; r < NA; r++)
          map_q[t][r] <= PW'(t * NA + r);
    end else if (cm_en) begin
      map_q[cm_tid][cm_a] <= cm_p;
    end
  end
endmodule

// File: rtl/thread_rename_free_pool.sv
module thread_rename_free_pool
  import thread_rename_pkg::*;
#(
  parameter int NT = 2,
  parameter int NA = 16,
  parameter int NP = 64,
  localparam int TW = $clog2(NT),
  localparam int PW = $clog2(NP)
) (
  input  logic           clk,
  input  logic           rst,
  output logic           any_free,
  output logic [PW-1:0]  alloc_p,
  input  logic           alloc_en,
  input  logic [TW-1:0]  alloc_tid,
  input  logic           rel_en,
  input  logic [PW-1:0]  rel_old,
  input  logic [PW-1:0]  rel_new,
  input  logic           fl_en,
  input  logic [TW-1:0]  fl_tid
);
  preg_state_e   st_q  [NP];
  preg_state_e   st_d  [NP];
  logic [TW-1:0] own_q [NP];
  logic [TW-1:0] own_d [NP];

  // Lowest-index free register wins
  always_comb begin
    alloc_p  = '0;
    any_free = 1'b0;
    for (int i = NP - 1; i >= 0; i--)
      if (st_q[i] == PR_FREE) begin
        alloc_p  = PW'(i);
        any_free = 1'b1;
      end
  end

  // Order: flush reclaim, then commit promotion, then new allocation
  always_comb begin
    for (int i = 0; i < NP; i++) begin
      st_d[i]  = st_q[i];
      own_d[i] = own_q[i];
      if (fl_en && st_q[i] == PR_SPEC && own_q[i] == fl_tid)
        st_d[i] = PR_FREE;
    end
    if (rel_en) begin
      st_d[rel_old] = PR_FREE;
      st_d[rel_new] = PR_ARCH;
    end
    if (alloc_en) begin
      st_d[alloc_p]  = PR_SPEC;
      own_d[alloc_p] = alloc_tid;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NP; i++) begin
        st_q[i]  <= (i < NT * NA) ? PR_ARCH : PR_FREE;
        own_q[i] <= TW'(i / NA);
      end
    end else begin
      for (int i = 0; i < NP; i++) begin
        st_q[i]  <= st_d[i];
        own_q[i] <= own_d[i];
      end
    end
  end
endmodule

// File: rtl/thread_rename_table.sv
module thread_rename_table #(
  parameter int NUM_THREADS = 2,
  parameter int NUM_AREGS   = 16,
  parameter int NUM_PREGS   = 64,
  localparam int TW = $clog2(NUM_THREADS),
  localparam int AW = $clog2(NUM_AREGS),
  localparam int PW = $clog2(NUM_PREGS)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           rn_valid,
  input  logic [TW-1:0]  rn_tid,
  input  logic [AW-1:0]  rn_src0,
  input  logic [AW-1:0]  rn_src1,
  input  logic           rn_dst_en,
  input  logic [AW-1:0]  rn_dst,
  output logic           rn_ready,
  input  logic           cm_valid,
  input  logic [TW-1:0]  cm_tid,
  input  logic [AW-1:0]  cm_areg,
  input  logic [PW-1:0]  cm_ptag,
  input  logic           fl_valid,
  input  logic [TW-1:0]  fl_tid,
  output logic           out_valid,
  output logic [TW-1:0]  out_tid,
  output logic           out_dst_en,
  output logic [PW-1:0]  out_ps0,
  output logic [PW-1:0]  out_ps1,
  output logic [PW-1:0]  out_pd
);
  logic                  pool_any_free;
  logic [PW-1:0]         pool_alloc_p;
  logic [PW-1:0]         arch_old_p;
  logic [NUM_AREGS-1:0][PW-1:0] arch_row_nxt;
  logic [PW-1:0]         src0_p;
  logic [PW-1:0]         src1_p;
  logic                  rn_fire;
  logic                  alloc_go;

  assign rn_ready = !(fl_valid && fl_tid == rn_tid) && (!rn_dst_en || pool_any_free);
  assign rn_fire  = rn_valid && rn_ready;
  assign alloc_go = rn_fire && rn_dst_en;

  thread_rename_spec_map #(.NT(NUM_THREADS), .NA(NUM_AREGS), .NP(NUM_PREGS)) u_spec (
    .clk    (clk),
    .rst    (rst),
    .rd_tid (rn_tid),
    .rd_a0  (rn_src0),
    .rd_a1  (rn_src1),
    .rd_p0  (src0_p),
    .rd_p1  (src1_p),
    .wr_en  (alloc_go),
    .wr_tid (rn_tid),
    .wr_a   (rn_dst),
    .wr_p   (pool_alloc_p),
    .ld_en  (fl_valid),
    .ld_tid (fl_tid),
    .ld_row (arch_row_nxt)
  );

  thread_rename_arch_map #(.NT(NUM_THREADS), .NA(NUM_AREGS), .NP(NUM_PREGS)) u_arch (
    .clk     (clk),
    .rst     (rst),
    .cm_en   (cm_valid),
    .cm_tid  (cm_tid),
    .cm_a    (cm_areg),
    .cm_p    (cm_ptag),
    .old_p   (arch_old_p),
    .row_tid (fl_tid),
    .row_nxt (arch_row_nxt)
  );

  thread_rename_free_pool #(.NT(NUM_THREADS), .NA(NUM_AREGS), .NP(NUM_PREGS)) u_pool (
    .clk       (clk),
    .rst       (rst),
    .any_free  (pool_any_free),
    .alloc_p   (pool_alloc_p),
    .alloc_en  (alloc_go),
    .alloc_tid (rn_tid),
    .rel_en    (cm_valid),
    .rel_old   (arch_old_p),
    .rel_new   (cm_ptag),
    .fl_en     (fl_valid),
    .fl_tid    (fl_tid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_tid    <= '0;
      out_dst_en <= 1'b0;
      out_ps0    <= '0;
      out_ps1    <= '0;
      out_pd     <= '0;
    end else begin
      out_valid <= rn_fire;
      if (rn_fire) begin
        out_tid    <= rn_tid;
        out_dst_en <= rn_dst_en;
        out_ps0    <= src0_p;
        out_ps1    <= src1_p;
        out_pd     <= pool_alloc_p;
      end
    end
  end
endmodule

// File: rtl/thread_rename_table_chk.sv
module thread_rename_table_chk #(
  parameter int TW = 1,
  parameter int PW = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          rn_valid,
  input logic [TW-1:0] rn_tid,
  input logic          rn_dst_en,
  input logic          rn_ready,
  input logic          fl_valid,
  input logic [TW-1:0] fl_tid,
  input logic          out_valid,
  input logic [TW-1:0] out_tid,
  input logic          out_dst_en,
  input logic [PW-1:0] out_ps0,
  input logic [PW-1:0] out_ps1,
  input logic [PW-1:0] out_pd,
  input logic          any_free
);
  a_r10_out_follows_accept: assert property (@(posedge clk) disable iff (rst)
    (rn_valid && rn_ready) |=> out_valid);

  a_r10_no_spurious_out: assert property (@(posedge clk) disable iff (rst)
    !(rn_valid && rn_ready) |=> !out_valid);

  a_r10_tid_echo: assert property (@(posedge clk) disable iff (rst)
    (rn_valid && rn_ready) |=> out_tid == $past(rn_tid));

  a_r9_flush_blocks_thread: assert property (@(posedge clk) disable iff (rst)
    (fl_valid && rn_tid == fl_tid) |-> !rn_ready);

  a_r5_empty_stalls: assert property (@(posedge clk) disable iff (rst)
    (rn_valid && rn_dst_en && !any_free) |-> !rn_ready);

  a_r5_nodst_proceeds: assert property (@(posedge clk) disable iff (rst)
    (rn_valid && !rn_dst_en && !fl_valid) |-> rn_ready);

  a_r3_fresh_tag: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_dst_en) |-> (out_pd != out_ps0 && out_pd != out_ps1));
endmodule

bind thread_rename_table thread_rename_table_chk #(.TW(TW), .PW(PW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .rn_valid   (rn_valid),
  .rn_tid     (rn_tid),
  .rn_dst_en  (rn_dst_en),
  .rn_ready   (rn_ready),
  .fl_valid   (fl_valid),
  .fl_tid     (fl_tid),
  .out_valid  (out_valid),
  .out_tid    (out_tid),
  .out_dst_en (out_dst_en),
  .out_ps0    (out_ps0),
  .out_ps1    (out_ps1),
  .out_pd     (out_pd),
  .any_free   (pool_any_free)
);

// File: tb/thread_rename_table_tb.sv
`timescale 1ns/1ps
module thread_rename_table_tb;
  localparam int NT = 2, NA = 16, NP = 64;
  localparam int ST_FREE = 0, ST_SPEC = 1, ST_ARCH = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rn_valid = 1'b0, rn_tid = 1'b0, rn_dst_en = 1'b0;
  logic [3:0] rn_src0 = '0, rn_src1 = '0, rn_dst = '0;
  logic rn_ready;
  logic cm_valid = 1'b0, cm_tid = 1'b0;
  logic [3:0] cm_areg = '0;
  logic [5:0] cm_ptag = '0;
  logic fl_valid = 1'b0, fl_tid = 1'b0;
  logic out_valid, out_tid, out_dst_en;
  logic [5:0] out_ps0, out_ps1, out_pd;

  always #2.5 clk = ~clk;

  thread_rename_table u_dut (.*);

  int n_checks = 0, n_errors = 0;
  bit finished = 1'b0;
  string cur_req = "R2";

  // Reference model of the requirements
  int m_spec [NT][NA];
  int m_arch [NT][NA];
  int m_st   [NP];
  int m_own  [NP];

  // Scoreboard queues
  int    q_tid[$], q_ps0[$], q_ps1[$], q_den[$], q_pd[$];
  string q_req[$];

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int lowest_free();
    for (int i = 0; i < NP; i++) if (m_st[i] == ST_FREE) return i;
    return -1;
  endfunction

  task automatic model_reset();
    for (int t = 0; t < NT; t++)
      for (int r = 0; r < NA; r++) begin
        m_spec[t][r] = t * NA + r;
        m_arch[t][r] = t * NA + r;
      end
    for (int i = 0; i < NP; i++) begin
      m_st[i]  = (i < NT * NA) ? ST_ARCH : ST_FREE;
      m_own[i] = i / NA;
    end
  endtask

  task automatic set_rn(int t, int s0, int s1, bit den, int d, string req);
    rn_valid = 1'b1; rn_tid = t[0]; rn_src0 = s0[3:0]; rn_src1 = s1[3:0];
    rn_dst_en = den; rn_dst = d[3:0]; cur_req = req;
  endtask

  task automatic set_cm(int t, int a, int p);
    cm_valid = 1'b1; cm_tid = t[0]; cm_areg = a[3:0]; cm_ptag = p[5:0];
  endtask

  task automatic set_fl(int t);
    fl_valid = 1'b1; fl_tid = t[0];
  endtask

  // Apply one cycle: check ready, predict, advance model, clock
  task automatic tick();
    bit exp_rdy, acc;
    int t, pd;
    #1;
    t = int'(rn_tid);
    exp_rdy = !(fl_valid && fl_tid == rn_tid) && (!rn_dst_en || lowest_free() >= 0);
    if (rn_valid)
      chk(rn_ready == exp_rdy, (fl_valid && fl_tid == rn_tid) ? "R9" : "R5",
          "rn_ready", int'(rn_ready), int'(exp_rdy));
    acc = rn_valid && exp_rdy;
    pd = -1;
    if (acc) begin
      pd = rn_dst_en ? lowest_free() : 0;
      q_tid.push_back(t);
      q_ps0.push_back(m_spec[t][rn_src0]);
      q_ps1.push_back(m_spec[t][rn_src1]);
      q_den.push_back(int'(rn_dst_en));
      q_pd.push_back(pd);
      q_req.push_back(cur_req);
    end
    if (cm_valid) begin
      int ct, old;
      ct = int'(cm_tid);
      old = m_arch[ct][cm_areg];
      m_st[old] = ST_FREE;
      m_arch[ct][cm_areg] = int'(cm_ptag);
      m_st[cm_ptag] = ST_ARCH;
    end
    if (fl_valid) begin
      int ft;
      ft = int'(fl_tid);
      for (int i = 0; i < NP; i++)
        if (m_st[i] == ST_SPEC && m_own[i] == ft) m_st[i] = ST_FREE;
      for (int r = 0; r < NA; r++) m_spec[ft][r] = m_arch[ft][r];
    end
    if (acc && rn_dst_en) begin
      m_st[pd] = ST_SPEC;
      m_own[pd] = t;
      m_spec[t][rn_dst] = pd;
    end
    @(posedge clk);
    @(negedge clk);
    rn_valid = 1'b0; rn_dst_en = 1'b0; cm_valid = 1'b0; fl_valid = 1'b0;
  endtask

  // Monitor: compare every produced result with the oldest expectation
  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (out_valid) begin
        if (q_tid.size() == 0) begin
          chk(1'b0, "R10", "out_valid without accepted rename", 1, 0);
        end else begin
          int e_tid, e_ps0, e_ps1, e_den, e_pd;
          string rq;
          e_tid = q_tid.pop_front(); e_ps0 = q_ps0.pop_front();
          e_ps1 = q_ps1.pop_front(); e_den = q_den.pop_front();
          e_pd = q_pd.pop_front(); rq = q_req.pop_front();
          chk(int'(out_tid) == e_tid, "R10", "out_tid", int'(out_tid), e_tid);
          chk(int'(out_ps0) == e_ps0, rq, "out_ps0", int'(out_ps0), e_ps0);
          chk(int'(out_ps1) == e_ps1, rq, "out_ps1", int'(out_ps1), e_ps1);
          chk(int'(out_dst_en) == e_den, "R10", "out_dst_en", int'(out_dst_en), e_den);
          if (e_den != 0)
            chk(int'(out_pd) == e_pd, "R3", "out_pd", int'(out_pd), e_pd);
        end
      end else if (q_tid.size() != 0) begin
        chk(1'b0, "R10", "missing out_valid", 0, 1);
        void'(q_tid.pop_front()); void'(q_ps0.pop_front()); void'(q_ps1.pop_front());
        void'(q_den.pop_front()); void'(q_pd.pop_front()); void'(q_req.pop_front());
      end
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1'b1;
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R10", "out_valid in reset", int'(out_valid), 0);
    rst = 1'b0;

    // R1 / R2: reset mappings, distinct per thread
    set_rn(0, 0, 15, 0, 0, "R1"); tick();
    set_rn(1, 0, 15, 0, 0, "R1"); tick();
    set_rn(1, 7, 3, 0, 0, "R2"); tick();

    // R4: source equal to own destination sees the prior tag; next sees new
    set_rn(0, 1, 2, 1, 1, "R4"); tick();
    set_rn(0, 1, 1, 0, 0, "R4"); tick();
    set_rn(1, 1, 1, 0, 0, "R2"); tick();

    // R3 / R5: drain the pool, then stall with a destination
    for (int k = 0; k < 31; k++) begin
      set_rn(0, 2 + (k % 14), 0, 1, 2 + (k % 14), "R3"); tick();
    end
    set_rn(1, 4, 5, 1, 6, "R5"); tick();
    set_rn(1, 4, 5, 0, 0, "R5"); tick();

    // R6: commit frees the old architected tag, which is then reused
    set_cm(0, 1, 32); tick();
    set_rn(1, 6, 9, 1, 6, "R6"); tick();
    set_rn(1, 6, 9, 0, 0, "R6"); tick();

    // R7 / R8: flush thread 0; thread 1 keeps its speculative mapping
    set_fl(0); tick();
    set_rn(0, 1, 2, 0, 0, "R7"); tick();
    set_rn(0, 3, 15, 0, 0, "R7"); tick();
    set_rn(1, 6, 1, 0, 0, "R8"); tick();
    set_rn(0, 5, 5, 1, 5, "R7"); tick();

    // R9: flush of thread 1 blocks its own rename but not thread 0's
    set_rn(1, 2, 3, 1, 2, "R9"); set_fl(1); tick();
    set_rn(0, 2, 3, 1, 2, "R9"); set_fl(1); tick();
    set_rn(1, 6, 2, 0, 0, "R8"); tick();

    // R7: commit and flush of the same thread in one cycle
    set_rn(0, 3, 3, 1, 3, "R7"); tick();
    set_cm(0, 3, m_spec[0][3]); set_fl(0); tick();
    set_rn(0, 3, 2, 0, 0, "R7"); tick();

    // Mixed traffic
    for (int k = 0; k < 600; k++) begin
      int op, t;
      op = $urandom_range(0, 9);
      t  = $urandom_range(0, 1);
      if (op < 6) begin
        set_rn(t, $urandom_range(0, 15), $urandom_range(0, 15), op < 4,
               $urandom_range(0, 15), "R2");
      end
      if (op == 6 || op == 7) begin
        int st, a;
        st = $urandom_range(0, 15);
        for (int j = 0; j < NA; j++) begin
          a = (st + j) % NA;
          if (m_st[m_spec[t][a]] == ST_SPEC) begin
            set_cm(t, a, m_spec[t][a]);
            break;
          end
        end
      end
      if (op == 8) set_fl(t);
      if (op == 9) begin
        set_fl(t);
        set_rn(1 - t, $urandom_range(0, 15), $urandom_range(0, 15), 1,
               $urandom_range(0, 15), "R8");
      end
      tick();
    end
    repeat (3) @(negedge clk);
    chk(q_tid.size() == 0, "R10", "pending expectations", q_tid.size(), 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule